// File: doc/BRIEF.md
# Eight-Channel Output Compare Unit with Master Override

This block generates timed pin events from a free-running 16-bit counter. Each of eight channels holds a compare value, an output-compare enable bit and a two-bit pin action. When the running count equals a channel's compare value, the channel applies its action to its pin latch and raises its interrupt flag. Software can also fire any channel's action on demand through a strobe register. A forced action changes the pin but never raises the flag, and it wins over a real match on the same channel in the same cycle.

The highest channel, channel 7, acts as a master. A channel 7 match copies selected bits of a master data register straight onto the pins chosen by a master mask. This copy overrides what the other channels would do in that cycle. All configuration goes through a single-cycle register write port with combinational read data.

Top module: `oc_unit`

## Requirements
- R1: With the enable bit (offset 0x00, bit 0) set, the count at offset 0x01 rises by one per cycle and wraps from 0xFFFF to 0x0000. With the bit clear it holds. A write to 0x01 loads it.
- R2: A channel matches in a cycle when the timer is enabled, its select bit (offset 0x02, bit i) is 1, and the count equals its compare register (offset 0x10+i). At the next clock edge the pin takes the action result and flag bit i (offset 0x07) becomes 1. Channels with select bit 0 never match.
- R3: The action field of channel i is bits [2i+1:2i] of offset 0x03. The codes are 00 leave pin, 01 toggle, 10 drive 0 and 11 drive 1.
- R4: Writing 1 to bit i of the force strobe (offset 0x04) applies channel i's action to its pin at the next edge, whatever its select bit. The flag is not set.
- R5: Reads of offset 0x04 always return zero.
- R6: When a force and a real match hit the same channel in one cycle, the action is applied once and the flag stays 0.
- R7: On a channel 7 match, each pin i whose mask bit (offset 0x05) is 1 loads bit i of the master data register (offset 0x06). This takes priority over channel i's own match action. Pins with mask bit 0 follow their own channel.
- R8: The master copy reaches pin i only when select bit i is 1.
- R9: After reset, all registers, the count, the pins, the flags and the interrupts are zero.
- R10: Writing 1 to a bit at offset 0x07 clears that flag. A new match in the same cycle wins over the clear. Interrupt output i is flag i AND enable bit i (offset 0x08).
- R11: Drive-enable output i equals select bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| oc_pin | output | 8 | Pin latch values |
| oc_drive | output | 8 | Pin drive enables |
| oc_irq | output | 8 | Per-channel interrupt requests |

## Verification
Every action code is applied to every channel through the force strobe, starting from both a low and a high pin. This separates the four codes and shows that forcing leaves the flags alone. The same sweep is repeated with real matches timed to an exact counter value, so flag setting, clearing and interrupt gating are seen per channel. Three further patterns are tried: a force landing in the very cycle of a match, both on the same channel and on a different channel, to tell the precedence rule apart from plain coincidence; a master match with mixed mask, select and data bits, run with all-zero and all-one data, to separate masked, unmasked and unselected pins; and counter loads at and across the wrap point.

// File: rtl/oc_pkg.sv
package oc_pkg;

    localparam int OC_NCH = 8;
    localparam int OC_CW  = 16;
    localparam int OC_DW  = 16;
    localparam int OC_AW  = 5;

    localparam logic [OC_AW-1:0] OC_A_CTRL  = 5'h00;
    localparam logic [OC_AW-1:0] OC_A_COUNT = 5'h01;
    localparam logic [OC_AW-1:0] OC_A_SEL   = 5'h02;
    localparam logic [OC_AW-1:0] OC_A_ACT   = 5'h03;
    localparam logic [OC_AW-1:0] OC_A_FORCE = 5'h04;
    localparam logic [OC_AW-1:0] OC_A_MASK  = 5'h05;
    localparam logic [OC_AW-1:0] OC_A_MDATA = 5'h06;
    localparam logic [OC_AW-1:0] OC_A_FLAG  = 5'h07;
    localparam logic [OC_AW-1:0] OC_A_IEN   = 5'h08;
    localparam logic [OC_AW-1:0] OC_A_CMP0  = 5'h10;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } oc_act_e;

    typedef struct packed {
        logic             sel;
        oc_act_e          act;
        logic [OC_CW-1:0] cmp;
    } oc_chan_cfg_t;

    function automatic logic oc_apply(oc_act_e a, logic cur);
        case (a)
            ACT_TOGGLE: return ~cur;
            ACT_CLEAR:  return 1'b0;
            ACT_SET:    return 1'b1;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/oc_counter.sv
module oc_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (en)
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/oc_regs.sv
module oc_regs
    import oc_pkg::*;
#(
    parameter int NCH = OC_NCH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [OC_AW-1:0]    bus_addr,
    input  logic [OC_DW-1:0]    bus_wdata,
    output logic [OC_DW-1:0]    bus_rdata,
    input  logic [OC_CW-1:0]    cnt,
    input  logic [NCH-1:0]      flags,
    output logic                tmr_en,
    output oc_chan_cfg_t        cfg [NCH],
    output logic [NCH-1:0]      mask,
    output logic [NCH-1:0]      mdata,
    output logic [NCH-1:0]      ien,
    output logic [NCH-1:0]      force_stb,
    output logic [NCH-1:0]      flag_clr,
    output logic                cnt_load,
    output logic [OC_CW-1:0]    cnt_val
);
    localparam int ACT_W = 2 * NCH;

    logic               en_q;
    logic [NCH-1:0]     sel_q, mask_q, mdata_q, ien_q;
    logic [ACT_W-1:0]   act_q;
    logic [OC_CW-1:0]   cmp_q [NCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            sel_q   <= '0;
            mask_q  <= '0;
            mdata_q <= '0;
            ien_q   <= '0;
            act_q   <= '0;
            for (int i = 0; i < NCH; i++) cmp_q[i] <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                OC_A_CTRL:  en_q    <= bus_wdata[0];
                OC_A_SEL:   sel_q   <= bus_wdata[NCH-1:0];
                OC_A_ACT:   act_q   <= bus_wdata[ACT_W-1:0];
                OC_A_MASK:  mask_q  <= bus_wdata[NCH-1:0];
                OC_A_MDATA: mdata_q <= bus_wdata[NCH-1:0];
                OC_A_IEN:   ien_q   <= bus_wdata[NCH-1:0];
                default: begin
                    for (int i = 0; i < NCH; i++)
                        if (bus_addr == OC_AW'(int'(OC_A_CMP0) + i))
                            cmp_q[i] <= bus_wdata[OC_CW-1:0];
                end
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OC_A_CTRL:  bus_rdata[0]         = en_q;
            OC_A_COUNT: bus_rdata[OC_CW-1:0] = cnt;
            OC_A_SEL:   bus_rdata[NCH-1:0]   = sel_q;
            OC_A_ACT:   bus_rdata[ACT_W-1:0] = act_q;
            OC_A_MASK:  bus_rdata[NCH-1:0]   = mask_q;
            OC_A_MDATA: bus_rdata[NCH-1:0]   = mdata_q;
            OC_A_FLAG:  bus_rdata[NCH-1:0]   = flags;
            OC_A_IEN:   bus_rdata[NCH-1:0]   = ien_q;
            default: begin
                for (int i = 0; i < NCH; i++)
                    if (bus_addr == OC_AW'(int'(OC_A_CMP0) + i))
                        bus_rdata[OC_CW-1:0] = cmp_q[i];
            end
        endcase
    end

    assign force_stb = (bus_we && bus_addr == OC_A_FORCE) ? bus_wdata[NCH-1:0] : '0;
    assign flag_clr  = (bus_we && bus_addr == OC_A_FLAG)  ? bus_wdata[NCH-1:0] : '0;
    assign cnt_load  = bus_we && (bus_addr == OC_A_COUNT);
    assign cnt_val   = bus_wdata[OC_CW-1:0];
    assign tmr_en    = en_q;
    assign mask      = mask_q;
    assign mdata     = mdata_q;
    assign ien       = ien_q;

    for (genvar g = 0; g < NCH; g++) begin : g_cfg
        assign cfg[g] = '{sel: sel_q[g], act: oc_act_e'(act_q[2*g +: 2]), cmp: cmp_q[g]};
    end
endmodule

// File: rtl/oc_chan.sv
module oc_chan
    import oc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  oc_chan_cfg_t     cfg,
    input  logic [OC_CW-1:0] cnt,
    input  logic             tmr_en,
    input  logic             force_stb,
    input  logic             ovr_hit,
    input  logic             ovr_val,
    input  logic             flag_clr,
    output logic             match,
    output logic             pin,
    output logic             flag
);
    assign match = tmr_en && cfg.sel && (cnt == cfg.cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin  <= 1'b0;
            flag <= 1'b0;
        end else begin
            if (force_stb)
                pin <= oc_apply(cfg.act, pin);
            else if (ovr_hit)
                pin <= ovr_val;
            else if (match)
                pin <= oc_apply(cfg.act, pin);

            if (match && !force_stb)
                flag <= 1'b1;
            else if (flag_clr)
                flag <= 1'b0;
        end
    end
endmodule

// File: rtl/oc_unit.sv
module oc_unit
    import oc_pkg::*;
#(
    parameter int NCH = OC_NCH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [OC_AW-1:0]  bus_addr,
    input  logic [OC_DW-1:0]  bus_wdata,
    output logic [OC_DW-1:0]  bus_rdata,
    output logic [NCH-1:0]    oc_pin,
    output logic [NCH-1:0]    oc_drive,
    output logic [NCH-1:0]    oc_irq
);
    localparam int MASTER = NCH - 1;

    logic               tmr_en, cnt_load;
    logic [OC_CW-1:0]   cnt, cnt_val;
    oc_chan_cfg_t       cfg [NCH];
    logic [NCH-1:0]     mask, mdata, ien, force_stb, flag_clr;
    logic [NCH-1:0]     match, flags, ovr_hit;

    oc_regs #(.NCH(NCH)) u_regs (
        .clk(clk), .rst(rst),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt(cnt), .flags(flags), .tmr_en(tmr_en), .cfg(cfg),
        .mask(mask), .mdata(mdata), .ien(ien),
        .force_stb(force_stb), .flag_clr(flag_clr),
        .cnt_load(cnt_load), .cnt_val(cnt_val)
    );

    oc_counter #(.CW(OC_CW)) u_cnt (
        .clk(clk), .rst(rst), .en(tmr_en),
        .load(cnt_load), .load_val(cnt_val), .cnt(cnt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ovr_hit[g]  = match[MASTER] & mask[g] & cfg[g].sel;
        assign oc_drive[g] = cfg[g].sel;

        oc_chan u_ch (
            .clk(clk), .rst(rst), .cfg(cfg[g]), .cnt(cnt), .tmr_en(tmr_en),
            .force_stb(force_stb[g]), .ovr_hit(ovr_hit[g]), .ovr_val(mdata[g]),
            .flag_clr(flag_clr[g]), .match(match[g]), .pin(oc_pin[g]), .flag(flags[g])
        );
    end

    assign oc_irq = flags & ien;
endmodule

// File: rtl/oc_unit_chk.sv
module oc_unit_chk
    import oc_pkg::*;
#(
    parameter int NCH = OC_NCH
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_we,
    input logic [OC_AW-1:0] bus_addr,
    input logic [OC_DW-1:0] bus_rdata,
    input logic [OC_CW-1:0] cnt,
    input logic             tmr_en,
    input logic [NCH-1:0]   match,
    input logic [NCH-1:0]   flags,
    input logic [NCH-1:0]   force_stb,
    input logic [NCH-1:0]   pins
);
    logic ld;
    assign ld = bus_we && (bus_addr == OC_A_COUNT);

    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        (tmr_en && !ld) |=> (cnt == $past(cnt) + OC_CW'(1)));

    p_count_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!tmr_en && !ld) |=> $stable(cnt));

    p_force_reads_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OC_A_FORCE) |-> (bus_rdata == '0));

    p_force_no_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (|(force_stb & ~flags)) |=> ((flags & $past(force_stb & ~flags)) == '0));

    p_match_sets_flag_r2: assert property (@(posedge clk) disable iff (rst)
        (|(match & ~force_stb)) |=> ((flags & $past(match & ~force_stb)) == $past(match & ~force_stb)));

    p_quiet_pins_r2: assert property (@(posedge clk) disable iff (rst)
        (force_stb == '0 && match == '0) |=> $stable(pins));
endmodule

bind oc_unit oc_unit_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .cnt(cnt), .tmr_en(tmr_en), .match(match), .flags(flags),
    .force_stb(force_stb), .pins(oc_pin)
);

// File: tb/oc_unit_tb.sv
module oc_unit_tb;
    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] A_CTRL = 5'h00, A_COUNT = 5'h01, A_SEL = 5'h02, A_ACT = 5'h03,
                           A_FORCE = 5'h04, A_MASK = 5'h05, A_MDATA = 5'h06,
                           A_FLAG = 5'h07, A_IEN = 5'h08, A_CMP0 = 5'h10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_we;
    logic [4:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [7:0]  oc_pin, oc_drive, oc_irq;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0]  e_pin, e_flag, b_sel, b_mask, b_mdata;
    logic [15:0] b_act;
    logic [15:0] rv;

    oc_unit u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .oc_pin(oc_pin), .oc_drive(oc_drive), .oc_irq(oc_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic act_f(input logic [1:0] a, input logic cur);
        case (a)
            2'b01: return ~cur;
            2'b10: return 1'b0;
            2'b11: return 1'b1;
            default: return cur;
        endcase
    endfunction

    // bench model of one event cycle: match vector m, force vector f
    task automatic model(input logic [7:0] m, input logic [7:0] f);
        logic [7:0] nxt;
        for (int i = 0; i < 8; i++) begin
            if (f[i])                                  nxt[i] = act_f(b_act[2*i +: 2], e_pin[i]);
            else if (m[7] && b_mask[i] && b_sel[i])    nxt[i] = b_mdata[i];
            else if (m[i])                             nxt[i] = act_f(b_act[2*i +: 2], e_pin[i]);
            else                                       nxt[i] = e_pin[i];
        end
        e_pin  = nxt;
        e_flag = e_flag | (m & ~f);
    endtask

    task automatic set_act(input logic [15:0] a);
        b_act = a; wr(A_ACT, a);
    endtask

    task automatic prime(input logic [7:0] p);
        logic [15:0] a = '0;
        for (int i = 0; i < 8; i++) a[2*i +: 2] = p[i] ? 2'b11 : 2'b10;
        set_act(a);
        wr(A_FORCE, 16'h00FF);
        e_pin = p;
    endtask

    // runs the timer from k so that count k+2 is compared exactly once;
    // fmask is driven on the force strobe during that compare cycle
    task automatic fire(input logic [15:0] k, input logic [7:0] fmask);
        wr(A_CTRL, 16'h0000);
        wr(A_COUNT, k);
        wr(A_CTRL, 16'h0001);
        @(negedge clk);
        @(negedge clk);
        if (fmask != 8'h00) begin
            bus_we = 1'b1; bus_addr = A_FORCE; bus_wdata = {8'h00, fmask};
        end
        @(negedge clk);
        bus_we = 1'b0;
        repeat (2) @(negedge clk);
        wr(A_CTRL, 16'h0000);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v0;
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state
        for (int a = 0; a < 9; a++) begin
            rd(5'(a), rv); check("R9 reg", rv, 16'h0);
        end
        for (int i = 0; i < 8; i++) begin
            rd(5'(int'(A_CMP0) + i), rv); check("R9 cmp", rv, 16'h0);
        end
        check("R9 pins", {8'h0, oc_pin}, 16'h0);
        check("R9 irq", {8'h0, oc_irq}, 16'h0);
        e_pin = '0; e_flag = '0; b_mask = '0; b_mdata = '0; b_act = '0;

        // R1: load, hold, count, wrap
        wr(A_COUNT, 16'h1234);
        rd(A_COUNT, rv); check("R1 load", rv, 16'h1234);
        repeat (3) @(negedge clk);
        rd(A_COUNT, rv); check("R1 hold", rv, 16'h1234);
        wr(A_CTRL, 16'h0001);
        rd(A_COUNT, v0); check("R1 start", v0, 16'h1234);
        repeat (5) @(negedge clk);
        rd(A_COUNT, rv); check("R1 step", rv, v0 + 16'd5);
        wr(A_CTRL, 16'h0000);
        rd(A_COUNT, v0);
        repeat (4) @(negedge clk);
        rd(A_COUNT, rv); check("R1 stop", rv, v0);
        wr(A_COUNT, 16'hFFFF);
        wr(A_CTRL, 16'h0001);
        rd(A_COUNT, rv); check("R1 pre-wrap", rv, 16'hFFFF);
        @(negedge clk);
        rd(A_COUNT, rv); check("R1 wrap", rv, 16'h0000);
        wr(A_CTRL, 16'h0000);

        // R11: drive enables follow select
        b_sel = 8'hA5; wr(A_SEL, {8'h0, b_sel});
        check("R11 drive", {8'h0, oc_drive}, 16'h00A5);
        b_sel = 8'hFF; wr(A_SEL, 16'h00FF);
        check("R11 drive all", {8'h0, oc_drive}, 16'h00FF);

        // R3/R4/R5: every action on every channel via force, from both levels
        for (int ch = 0; ch < 8; ch++) begin
            for (int st = 0; st < 2; st++) begin
                for (int a = 0; a < 4; a++) begin
                    prime(st != 0 ? 8'hFF : 8'h00);
                    set_act(16'(a) << (2 * ch));
                    wr(A_FORCE, 16'(1) << ch);
                    e_pin[ch] = act_f(2'(a), st != 0);
                    check("R3 force action", {8'h0, oc_pin}, {8'h0, e_pin});
                    rd(A_FLAG, rv); check("R4 no flag", rv, 16'h0);
                end
            end
        end
        rd(A_FORCE, rv); check("R5 force reads zero", rv, 16'h0);

        // R2/R3/R10: real matches, every channel and code
        wr(A_IEN, 16'h00FF);
        for (int ch = 0; ch < 8; ch++) begin
            for (int a = 0; a < 4; a++) begin
                prime(8'h5A);
                set_act(16'(a) << (2 * ch));
                wr(5'(int'(A_CMP0) + ch), 16'h2002);
                fire(16'h2000, 8'h00);
                model(8'(1) << ch, 8'h00);
                check("R2 match pin", {8'h0, oc_pin}, {8'h0, e_pin});
                rd(A_FLAG, rv); check("R2 match flag", rv, {8'h0, e_flag});
                check("R10 irq", {8'h0, oc_irq}, {8'h0, e_flag});
                wr(A_FLAG, 16'(1) << ch); e_flag = '0;
                rd(A_FLAG, rv); check("R10 clear", rv, 16'h0);
                check("R10 irq clear", {8'h0, oc_irq}, 16'h0);
                wr(5'(int'(A_CMP0) + ch), 16'h0100);
            end
        end

        // R10: gating by enable
        wr(A_IEN, 16'h00F0);
        set_act(16'h0000);
        wr(5'(int'(A_CMP0) + 1), 16'h3002);
        fire(16'h3000, 8'h00);
        check("R10 irq gated", {8'h0, oc_irq}, 16'h0);
        rd(A_FLAG, rv); check("R10 flag gated", rv, 16'h0002);
        wr(A_FLAG, 16'h00FF); wr(5'(int'(A_CMP0) + 1), 16'h0100);

        // R2: unselected channel never matches
        b_sel = 8'hF7; wr(A_SEL, {8'h0, b_sel});
        prime(8'h00);
        set_act(16'h0040);
        wr(5'(int'(A_CMP0) + 3), 16'h3102);
        fire(16'h3100, 8'h00);
        check("R2 unselected pin", {8'h0, oc_pin}, 16'h0);
        rd(A_FLAG, rv); check("R2 unselected flag", rv, 16'h0);
        wr(5'(int'(A_CMP0) + 3), 16'h0100);
        b_sel = 8'hFF; wr(A_SEL, 16'h00FF);

        // R6: force in the match cycle, same channel and other channel
        prime(8'h00);
        set_act(16'h0C10);
        wr(5'(int'(A_CMP0) + 2), 16'h4002);
        fire(16'h4000, 8'h24);
        model(8'h04, 8'h24);
        check("R6 pin once", {8'h0, oc_pin}, {8'h0, e_pin});
        rd(A_FLAG, rv); check("R6 no flag", rv, {8'h0, e_flag});
        prime(8'h00);
        set_act(16'h0C10);
        fire(16'h4000, 8'h20);
        model(8'h04, 8'h20);
        check("R6 other force pin", {8'h0, oc_pin}, {8'h0, e_pin});
        rd(A_FLAG, rv); check("R6 other flag", rv, {8'h0, e_flag});
        wr(A_FLAG, 16'h00FF); e_flag = '0;
        wr(5'(int'(A_CMP0) + 2), 16'h0100);

        // R7/R8: master override with mixed mask, select and data
        for (int dv = 0; dv < 2; dv++) begin
            b_sel = 8'hBF; wr(A_SEL, {8'h0, b_sel});
            b_mask = 8'h65; wr(A_MASK, {8'h0, b_mask});
            b_mdata = (dv != 0) ? 8'hFF : 8'h82; wr(A_MDATA, {8'h0, b_mdata});
            prime((dv != 0) ? 8'h00 : 8'h65);
            set_act(16'h4003);
            wr(5'(int'(A_CMP0) + 0), 16'h5002);
            wr(5'(int'(A_CMP0) + 7), 16'h5002);
            fire(16'h5000, 8'h00);
            model(8'h81, 8'h00);
            check("R7 override pins", {8'h0, oc_pin}, {8'h0, e_pin});
            check("R8 unselected pin6", {15'h0, oc_pin[6]}, {15'h0, (dv != 0) ? 1'b0 : 1'b1});
            rd(A_FLAG, rv); check("R7 flags", rv, {8'h0, e_flag});
            wr(A_FLAG, 16'h00FF); e_flag = '0;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule